// File: doc/BRIEF.md
# Single-Wire Identification ROM Responder

This block is the device end of a one-wire, open-drain identification link. It watches a sampled copy of the shared data line and drives a single pull-low enable toward an external open-drain pad. A long low period on the line resets the responder. The responder then answers with a presence pulse and listens for an 8-bit command sent in write time slots. When the command matches, it returns a 64-bit read-only identity word, one bit per read time slot started by the host.

All protocol timing is counted in microsecond ticks, taken from a free-running one-cycle enable, `tick_us_i`. The identity word is made of a family code, a 48-bit serial number and a check byte, and all three are parameters. By default the check byte is derived from the other 56 bits. Analog matters such as parasitic supply, pull-up strength and line capacitance are outside this block, and so are multi-device search and any command other than the one read command.

Top module: `owrom_responder`

## Requirements
- R1: After `rst_ni` is released, `pull_o` is 0 (line released), and it stays 0 until a line reset has been seen.
- R2: A line low of at least RST_US (480) microseconds is a line reset in every state: idle, presence, command, readout and muted. It releases `pull_o` and leads to a new presence pulse.
- R3: After the line returns high following a reset, the responder waits PD_WAIT_US (15) microseconds with the line released. It then pulls the line low for PD_LEN_US (120) microseconds. The measured wait lies in 5..50 µs and the measured pull lies in 60..240 µs.
- R4: The command arrives in 8 write slots, least significant bit first. Each slot starts at a falling edge, and the line level 30 µs after that edge is the bit (high = 1, low = 0). `pull_o` stays 0 throughout the command phase.
- R5: A command value of 0x0F, with bit 0 received first, enables readout starting at ROM bit 0.
- R6: In a read slot, when the current ROM bit is 0, the responder pulls the line low from just after the host's falling edge until 30 µs after that edge. When the bit is 1 it leaves the line released. The line level seen 15 µs after the edge therefore equals the ROM bit.
- R7: ROM bits go out bit 0 first. Bits 7:0 are the type code (default 0x81), bits 55:8 are the serial number, and bits 63:56 are the check byte. The check byte is the CRC of bits 55:0, taken least significant bit first with polynomial x^8+x^5+x^4+1 and an initial value of 0.
- R8: The read slot after the one that carried ROM bit 63 carries ROM bit 0 again, and the sequence continues from there.
- R9: A command other than 0x0F mutes the responder. Until the next line reset, `pull_o` stays 0 in every slot, and a later 0x0F command has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_us_i | input | 1 | One-cycle pulse once per microsecond |
| line_i | input | 1 | Data line level as seen at the pad (1 = high) |
| pull_o | output | 1 | Open-drain pull-low enable (1 = drive line low) |

## Verification
The hardest situations to reach are line resets that arrive in the middle of a partly read identity word, in the middle of a command, or while the responder is muted. In each case the reset must cut the operation short, and the responder must still produce a correctly timed presence pulse. The bench models the wire as the AND of the host's release and the inverse of `pull_o`. It abandons readout after a few bits, breaks off a command after three slots, and sends a bit-reversed command, then issues a long low. Each time it measures the presence wait and width in microseconds and then checks that readout restarts at bit 0.

// File: rtl/owrom_pkg.sv
package owrom_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RST_LOW,
    ST_PD_WAIT,
    ST_PD_DRIVE,
    ST_CMD,
    ST_READ,
    ST_MUTE
  } st_e;

  // reflected CRC, poly x^8+x^5+x^4+1, data taken bit 0 first
  function automatic logic [7:0] crc8_lsb(input logic [55:0] d);
    logic [7:0] c;
    logic       fb;
    c = '0;
    for (int i = 0; i < 56; i++) begin
      fb = c[0] ^ d[i];
      c  = c >> 1;
      if (fb) c = c ^ 8'h8C;
    end
    return c;
  endfunction

endpackage

// File: rtl/owrom_sync.sv
module owrom_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic line_o,
  output logic fall_o
);
  logic s1_q, s2_q, s3_q;

  // idle line is high; reset values avoid a false edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
      s3_q <= 1'b1;
    end else begin
      s1_q <= line_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign line_o = s2_q;
  assign fall_o = s3_q & ~s2_q;
endmodule

// File: rtl/owrom_lowtimer.sv
module owrom_lowtimer #(
  parameter int RST_US = 480
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  input  logic tick_i,
  output logic rst_det_o
);
  localparam int W = $clog2(RST_US + 1);

  logic [W-1:0] low_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_q <= '0;
    end else if (line_i) begin
      low_q <= '0;
    end else if (tick_i && low_q != W'(RST_US)) begin
      low_q <= low_q + 1'b1;
    end
  end

  // single pulse when the low run reaches the reset length
  assign rst_det_o = tick_i & ~line_i & (low_q == W'(RST_US - 1));

  p_rst_once_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_det_o |=> !rst_det_o);
endmodule

// File: rtl/owrom_fsm.sv
module owrom_fsm
  import owrom_pkg::*;
#(
  parameter int              ROM_W      = 64,
  parameter logic [ROM_W-1:0] ROM_BITS  = '0,
  parameter int              CMD_W      = 8,
  parameter logic [CMD_W-1:0] CMD_CODE  = 8'h0F,
  parameter int              PD_WAIT_US = 15,
  parameter int              PD_LEN_US  = 120,
  parameter int              SAMPLE_US  = 30,
  parameter int              HOLD_US    = 30
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  input  logic fall_i,
  input  logic tick_i,
  input  logic rst_det_i,
  output logic pull_o
);
  localparam int TW = $clog2(PD_WAIT_US + PD_LEN_US + SAMPLE_US + HOLD_US + 1);
  localparam int IW = $clog2(ROM_W);
  localparam int BW = $clog2(CMD_W);

  st_e              st_q;
  logic [TW-1:0]    tcnt_q;
  logic             slot_q;
  logic [BW-1:0]    bits_q;
  logic [CMD_W-1:0] cmd_q;
  logic [IW-1:0]    idx_q;
  logic             pull_q;
  logic [CMD_W-1:0] cmd_nxt;

  assign cmd_nxt = {line_i, cmd_q[CMD_W-1:1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      tcnt_q <= '0;
      slot_q <= 1'b0;
      bits_q <= '0;
      cmd_q  <= '0;
      idx_q  <= '0;
      pull_q <= 1'b0;   // R1
    end else if (rst_det_i) begin
      st_q   <= ST_RST_LOW;
      slot_q <= 1'b0;
      pull_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE, ST_MUTE: ;
        ST_RST_LOW: if (line_i) begin
          st_q   <= ST_PD_WAIT;
          tcnt_q <= '0;
        end
        ST_PD_WAIT: if (tick_i) begin
          if (tcnt_q == TW'(PD_WAIT_US - 1)) begin
            st_q   <= ST_PD_DRIVE;
            pull_q <= 1'b1;
            tcnt_q <= '0;
          end else tcnt_q <= tcnt_q + 1'b1;
        end
        ST_PD_DRIVE: if (tick_i) begin
          if (tcnt_q == TW'(PD_LEN_US - 1)) begin
            st_q   <= ST_CMD;
            pull_q <= 1'b0;
            bits_q <= '0;
            slot_q <= 1'b0;
          end else tcnt_q <= tcnt_q + 1'b1;
        end
        ST_CMD: begin
          if (fall_i) begin
            slot_q <= 1'b1;
            tcnt_q <= '0;
          end else if (slot_q && tick_i) begin
            if (tcnt_q == TW'(SAMPLE_US - 1)) begin
              slot_q <= 1'b0;
              cmd_q  <= cmd_nxt;
              bits_q <= bits_q + 1'b1;
              if (bits_q == BW'(CMD_W - 1)) begin
                st_q  <= (cmd_nxt == CMD_CODE) ? ST_READ : ST_MUTE;
                idx_q <= '0;
              end
            end else tcnt_q <= tcnt_q + 1'b1;
          end
        end
        ST_READ: begin
          if (fall_i) begin
            slot_q <= 1'b1;
            tcnt_q <= '0;
            pull_q <= ~ROM_BITS[idx_q];
          end else if (slot_q && tick_i) begin
            if (tcnt_q == TW'(HOLD_US - 1)) begin
              slot_q <= 1'b0;
              pull_q <= 1'b0;
              idx_q  <= (idx_q == IW'(ROM_W - 1)) ? '0 : idx_q + 1'b1;
            end else tcnt_q <= tcnt_q + 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign pull_o = pull_q;

  p_cmd_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_CMD) |-> !pull_q);
  p_mute_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_MUTE) |-> !pull_q);
  p_pd_wait_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_PD_WAIT) |-> !pull_q);
  p_rst_release_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_det_i |=> (!pull_q && st_q == ST_RST_LOW));
  p_read_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_READ && !slot_q) |-> !pull_q);
endmodule

// File: rtl/owrom_responder.sv
module owrom_responder #(
  parameter logic [7:0]  TYPE_CODE  = 8'h81,
  parameter logic [47:0] SERIAL_NUM = 48'h3A5C_96E1_0F42,
  parameter logic [7:0]  CRC_CODE   = owrom_pkg::crc8_lsb({SERIAL_NUM, TYPE_CODE}),
  parameter logic [7:0]  CMD_CODE   = 8'h0F,
  parameter int          RST_US     = 480,
  parameter int          PD_WAIT_US = 15,
  parameter int          PD_LEN_US  = 120,
  parameter int          SAMPLE_US  = 30,
  parameter int          HOLD_US    = 30
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_us_i,
  input  logic line_i,
  output logic pull_o
);
  localparam int ROM_W = 64;
  localparam logic [ROM_W-1:0] ROM_BITS = {CRC_CODE, SERIAL_NUM, TYPE_CODE};

  logic line_s, fall_s, rst_det;

  owrom_sync u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .line_i (line_i),
    .line_o (line_s),
    .fall_o (fall_s)
  );

  owrom_lowtimer #(.RST_US(RST_US)) u_lowtimer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .line_i    (line_s),
    .tick_i    (tick_us_i),
    .rst_det_o (rst_det)
  );

  owrom_fsm #(
    .ROM_W      (ROM_W),
    .ROM_BITS   (ROM_BITS),
    .CMD_W      (8),
    .CMD_CODE   (CMD_CODE),
    .PD_WAIT_US (PD_WAIT_US),
    .PD_LEN_US  (PD_LEN_US),
    .SAMPLE_US  (SAMPLE_US),
    .HOLD_US    (HOLD_US)
  ) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .line_i    (line_s),
    .fall_i    (fall_s),
    .tick_i    (tick_us_i),
    .rst_det_i (rst_det),
    .pull_o    (pull_o)
  );
endmodule

// File: tb/tb_owrom_responder.sv
module tb_owrom_responder;
  localparam int CPU = 5;  // clocks per microsecond tick

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic tick_us = 1'b0;
  logic host_rel = 1'b1;
  logic pull_o;
  wire  line = host_rel & ~pull_o;

  int checks = 0, errors = 0, nprint = 0;
  logic [1:0] exp_mode = 2'd2;   // 0 released, 1 pulled, 2 don't care
  string exp_req = "R1";
  logic [63:0] rom;
  bit done = 0;

  always #10 clk = ~clk;

  int tdiv = 0;
  always @(posedge clk) begin
    tdiv    <= (tdiv == CPU - 1) ? 0 : tdiv + 1;
    tick_us <= (tdiv == CPU - 1);
  end

  owrom_responder dut (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .tick_us_i (tick_us),
    .line_i    (line),
    .pull_o    (pull_o)
  );

  // per-clock comparison against the expected pull level
  always @(negedge clk) begin
    if (rst_ni && exp_mode != 2'd2) begin
      checks++;
      if (pull_o !== exp_mode[0]) begin
        errors++;
        if (nprint < 20) begin
          nprint++;
          $display("FAIL %s pull_o got %0b exp %0b at %0t", exp_req, pull_o, exp_mode[0], $time);
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s got %0d exp %0d", req, act, expv);
    end
  endtask

  task automatic wait_us(input int n);
    repeat (n * CPU) @(negedge clk);
  endtask

  task automatic host_reset(input string req);
    int rise_c, fall_c;
    logic prev;
    exp_req = req; exp_mode = 2'd2;
    host_rel = 1'b0;
    wait_us(35);
    exp_mode = 2'd0;
    wait_us(465);
    exp_mode = 2'd2;
    host_rel = 1'b1;
    rise_c = -1; fall_c = -1; prev = pull_o;
    for (int c = 0; c < 480 * CPU; c++) begin
      @(negedge clk);
      if (pull_o && !prev && rise_c < 0) rise_c = c;
      if (!pull_o && prev && fall_c < 0) fall_c = c;
      prev = pull_o;
    end
    exp_mode = 2'd0;
    chk(rise_c >= 0 && fall_c > rise_c, "R3 presence seen", fall_c, rise_c);
    chk(rise_c / CPU >= 13 && rise_c / CPU <= 17 && rise_c / CPU >= 5 && rise_c / CPU <= 50,
        "R3 presence wait us", rise_c / CPU, 15);
    chk((fall_c - rise_c) / CPU >= 118 && (fall_c - rise_c) / CPU <= 122,
        "R3 presence width us", (fall_c - rise_c) / CPU, 120);
  endtask

  task automatic write_bit(input bit b);
    exp_req = "R4"; exp_mode = 2'd0;
    host_rel = 1'b0;
    if (b) begin wait_us(3);  host_rel = 1'b1; wait_us(67); end
    else   begin wait_us(65); host_rel = 1'b1; wait_us(5);  end
  endtask

  task automatic write_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) write_bit(v[i]);
  endtask

  task automatic read_bit(input bit e, input string req, input int pos);
    logic got;
    exp_req = req;
    exp_mode = e ? 2'd0 : 2'd2;
    host_rel = 1'b0;
    wait_us(2);
    host_rel = 1'b1;
    if (!e) exp_mode = 2'd1;
    wait_us(13);
    got = line;
    checks++;
    if (got !== e) begin
      errors++;
      $display("FAIL %s bit %0d got %0b exp %0b", req, pos, got, e);
    end
    if (!e) begin
      wait_us(13); exp_mode = 2'd2; wait_us(5); exp_mode = 2'd0; wait_us(37);
    end else wait_us(55);
  endtask

  function automatic logic [7:0] ref_crc(input logic [55:0] d);
    int r = 0;
    int fb;
    logic [7:0] o;
    for (int i = 0; i < 56; i++) begin
      fb = ((r >> 7) & 1) ^ int'(d[i]);
      r  = (r << 1) & 255;
      if (fb != 0) r = r ^ 'h31;
    end
    for (int k = 0; k < 8; k++) o[k] = r[7-k];
    return o;
  endfunction

  initial begin
    rom[7:0]   = 8'h81;
    rom[55:8]  = 48'h3A5C_96E1_0F42;
    rom[63:56] = ref_crc(rom[55:0]);

    repeat (5) @(negedge clk);
    rst_ni = 1'b1;
    exp_req = "R1"; exp_mode = 2'd0;
    wait_us(3);
    chk(pull_o == 1'b0, "R1 reset state", pull_o, 0);
    // slots before any line reset get no answer (R1)
    for (int i = 0; i < 4; i++) read_bit(1'b1, "R1", i);

    // full readout and wrap
    host_reset("R2");
    write_byte(8'h0F);   // R5
    for (int i = 0; i < 64; i++)
      read_bit(rom[i], (i < 8) ? "R7 type" : (i < 56) ? "R7 serial" : "R7 crc", i);
    for (int i = 0; i < 16; i++) read_bit(rom[i], "R8 wrap", i);

    // reset in the middle of readout
    for (int i = 0; i < 10; i++) read_bit(rom[(16 + i) % 64], "R6", 16 + i);
    host_reset("R2 mid-read");
    write_byte(8'h0F);
    for (int i = 0; i < 8; i++) read_bit(rom[i], "R2 restart", i);

    // reset in the middle of a command
    host_reset("R2");
    for (int i = 0; i < 3; i++) write_bit(1'b1);
    host_reset("R2 mid-command");
    write_byte(8'h0F);
    for (int i = 0; i < 16; i++) read_bit(rom[i], "R5", i);

    // bit-reversed command must mute (R4 order, R9)
    host_reset("R2");
    write_byte(8'hF0);
    for (int i = 0; i < 8; i++) read_bit(1'b1, "R9 muted", i);
    write_byte(8'h0F);
    for (int i = 0; i < 8; i++) read_bit(1'b1, "R9 late cmd", i);

    // other wrong value, then recovery by reset
    host_reset("R2 from mute");
    write_byte(8'h0E);
    for (int i = 0; i < 8; i++) read_bit(1'b1, "R9 muted", i);
    host_reset("R2 from mute");
    write_byte(8'h0F);
    for (int i = 0; i < 64; i++) read_bit(rom[i], "R6", i);

    exp_mode = 2'd2;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule